// File: doc/BRIEF.md
# Indirect Register Access Bus Master

This block lets on-chip logic read and write 16-bit registers of an external peripheral that is reached through a narrow 8-bit asynchronous parallel bus. The peripheral shows only a few byte-wide registers at a 3-bit bus offset. It has a mode register, a pair of address-window registers and a pair of data-window registers. Every other register is reached through that window. The block hides the window from the requester. A single command carries a 16-bit target address, a read/write flag and 16-bit write data. The block expands it into a fixed train of four byte cycles, most significant byte first. It returns the assembled 16-bit read value together with a one-clock done pulse.

A second request type writes a single byte to the mode register. Software uses it to issue a peripheral reset (bit 7) or to switch the peripheral into windowed mode (bit 0). The block passes the byte through unchanged. Bus timing comes from three live inputs: address/data setup before chip select falls, strobe-low length, and idle gap after each byte cycle. This lets one design fit peripherals of different speeds.

Top module: `ind_reg_master`

## Requirements
- R1: Out of reset, and whenever busy is low, bus_cs_n, bus_rd_n and bus_wr_n are high, bus_oe is low, and done is low.
- R2: A write command (cmd_write=1) produces exactly four byte writes, in this order: offset 2 with address[15:8], offset 3 with address[7:0], offset 4 with data[15:8], offset 5 with data[7:0].
- R3: A read command (cmd_write=0) produces a byte write at offset 2 with address[15:8], then a byte write at offset 3 with address[7:0], then a byte read at offset 4, then a byte read at offset 5. rdata equals (first byte read << 8) | second byte read. Each byte is sampled on the last strobe-low clock, while chip select is still low, and rdata is valid when done pulses.
- R4: A mode request (mode_valid=1) produces exactly one byte write at offset 1 carrying mode_byte unchanged. Bit 0 of that byte enables windowed access and bit 7 requests a peripheral reset.
- R5: At most one strobe is low at a time, and a strobe is low only while bus_cs_n is low. During a write strobe bus_oe is 1 and bus_rd_n is 1. During a read strobe bus_oe is 0 and bus_wr_n is 1.
- R6: Each byte cycle holds bus_addr and bus_dout for cfg_setup+1 clocks with chip select high, then holds chip select and one strobe low for cfg_strobe+1 clocks, then idles for cfg_gap+1 clocks. bus_addr and bus_dout do not change between the setup phase and the rise of chip select. Between two byte cycles of one access, chip select stays high for exactly cfg_gap+cfg_setup+3 clocks.
- R7: Take the clock whose edge accepts a request as cycle 0. busy is high from cycle 1 through cycle N·(cfg_setup+cfg_strobe+cfg_gap+4), where N is 4 for a command and 1 for a mode request. done is high for exactly the next cycle, and busy is low in that cycle.
- R8: A command or mode request presented while busy is high is ignored: it produces no bus cycle and no peripheral register changes.
- R9: If cmd_valid and mode_valid are both high in the same idle cycle, the mode request is executed and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | 4 | Setup clocks minus one before chip select falls |
| cfg_strobe | input | 4 | Strobe-low clocks minus one |
| cfg_gap | input | 4 | Idle clocks minus one after each byte cycle |
| cmd_valid | input | 1 | Register access request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Target register address in the peripheral |
| cmd_wdata | input | 16 | Write data |
| mode_valid | input | 1 | Mode-register byte write request |
| mode_byte | input | 8 | Byte for the mode register |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data |
| bus_addr | output | 3 | Bus register offset |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Host drives the data bus when 1 |
| bus_dout | output | 8 | Data toward the peripheral |
| bus_din | input | 8 | Data from the peripheral |

## Verification
Two request types can arrive in the same cycle: a register command and a mode-byte write. A second request can also arrive while a command is still in flight. The bench raises both valid inputs in one idle cycle. It judges the result from the captured byte-cycle log, which must hold a single write at offset 1 and nothing at offsets 2 to 5, and from done arriving one byte-cycle length after acceptance. It also raises a command and a mode request mid-access. A later read of the injected address must then return its untouched initial value, and the access log must hold only the four original byte cycles.

// File: rtl/irm_pkg.sv
// Package: shared constants and types for the indirect register access master.
// Assumes the peripheral places its window registers at consecutive offsets.
package irm_pkg;
    // Byte cycle phases of the bus engine
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_GAP    = 2'd3
    } phase_t;

    // Bus offsets the peripheral decodes
    localparam int OFF_MODE   = 1;  // mode register low byte
    localparam int OFF_WINDOW = 2;  // first window register (address high)
endpackage

// File: rtl/irm_byte_cycle.sv
// Module: irm_byte_cycle
// Runs one asynchronous byte cycle: setup with chip select high, strobe low,
// then idle gap. All bus pins come from flops, so they do not glitch.
// Assumes start is only raised while idle is high, and the cfg_* inputs hold
// steady during a cycle.
module irm_byte_cycle
    import irm_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int OFF_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_strobe,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             start,
    input  logic [OFF_W-1:0] op_off,
    input  logic [BUS_W-1:0] op_data,
    input  logic             op_rd,
    output logic             idle,
    output logic             fin,
    output logic [BUS_W-1:0] rbyte,
    output logic [OFF_W-1:0] bus_addr,
    output logic             bus_cs_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_dout,
    input  logic [BUS_W-1:0] bus_din
);
    phase_t           ph_q, ph_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [OFF_W-1:0] off_q;
    logic [BUS_W-1:0] data_q;
    logic             rd_q;
    logic             rd_nx;
    logic             cs_n_q, rd_n_q, wr_n_q, oe_q;
    logic [BUS_W-1:0] rbyte_q;

    // Next phase and count from the current phase and its down-counter
    always_comb begin
        ph_n  = ph_q;
        cnt_n = cnt_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_n  = PH_SETUP;
                    cnt_n = cfg_setup;
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    ph_n  = PH_STROBE;
                    cnt_n = cfg_strobe;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    ph_n  = PH_GAP;
                    cnt_n = cfg_gap;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            PH_GAP: begin
                if (cnt_q == '0) begin
                    ph_n = PH_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // Direction of the byte cycle about to run (the latched one, or a new one)
    always_comb begin
        rd_nx = (ph_q == PH_IDLE && start) ? op_rd : rd_q;
    end

    // Phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
        end
    end

    // Latch the byte operation when a cycle starts; held until the next start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            data_q <= '0;
            rd_q   <= 1'b0;
        end else if (ph_q == PH_IDLE && start) begin
            off_q  <= op_off;
            data_q <= op_data;
            rd_q   <= op_rd;
        end
    end

    // Registered bus controls decoded from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            oe_q   <= 1'b0;
        end else begin
            cs_n_q <= (ph_n != PH_STROBE);
            rd_n_q <= !(ph_n == PH_STROBE && rd_nx);
            wr_n_q <= !(ph_n == PH_STROBE && !rd_nx);
            oe_q   <= (ph_n != PH_IDLE) && !rd_nx;
        end
    end

    // Sample the read byte on the last strobe-low clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_q <= '0;
        end else if (ph_q == PH_STROBE && cnt_q == '0 && rd_q) begin
            rbyte_q <= bus_din;
        end
    end

    assign idle     = (ph_q == PH_IDLE);
    assign fin      = (ph_q == PH_GAP) && (cnt_q == '0);
    assign rbyte    = rbyte_q;
    assign bus_addr = off_q;
    assign bus_dout = data_q;
    assign bus_cs_n = cs_n_q;
    assign bus_rd_n = rd_n_q;
    assign bus_wr_n = wr_n_q;
    assign bus_oe   = oe_q;
endmodule

// File: rtl/irm_access_seq.sv
// Module: irm_access_seq
// Accepts a register command or a mode byte and feeds the byte engine the
// window sequence (address bytes, then data bytes, high byte first). It puts
// read bytes together into the result.
// Assumes REG_W is twice BUS_W and the window registers are at consecutive offsets.
module irm_access_seq
    import irm_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int REG_W = 16,
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [REG_W-1:0] cmd_addr,
    input  logic [REG_W-1:0] cmd_wdata,
    input  logic             mode_valid,
    input  logic [BUS_W-1:0] mode_byte,
    input  logic             eng_idle,
    input  logic             eng_fin,
    input  logic [BUS_W-1:0] eng_rbyte,
    output logic             start,
    output logic [OFF_W-1:0] op_off,
    output logic [BUS_W-1:0] op_data,
    output logic             op_rd,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rdata
);
    localparam int HALVES = REG_W / BUS_W;
    localparam int STEPS  = 2 * HALVES;
    localparam int STEP_W = $clog2(STEPS);

    logic              busy_q, mode_q, write_q, launched_q, done_q;
    logic [STEP_W-1:0] step_q;
    logic [REG_W-1:0]  addr_q, wdata_q, rdata_q;
    logic [BUS_W-1:0]  mbyte_q, acc_q;
    logic [BUS_W-1:0]  seq_bytes [STEPS];
    logic              accept, last_step;

    // Byte order of the window: address bytes then data bytes, high first
    for (genvar g = 0; g < STEPS; g++) begin : g_bytes
        if (g < HALVES) begin : g_addr
            assign seq_bytes[g] = addr_q[(HALVES-1-g)*BUS_W +: BUS_W];
        end else begin : g_data
            assign seq_bytes[g] = wdata_q[(STEPS-1-g)*BUS_W +: BUS_W];
        end
    end

    // Request acceptance and the operation to hand to the engine
    always_comb begin
        accept    = !busy_q && (cmd_valid || mode_valid);
        last_step = mode_q || (step_q == STEP_W'(STEPS-1));
        start     = busy_q && eng_idle && !launched_q;
        if (mode_q) begin
            op_off  = OFF_W'(OFF_MODE);
            op_data = mbyte_q;
            op_rd   = 1'b0;
        end else begin
            op_off  = OFF_W'(OFF_WINDOW) + OFF_W'(step_q);
            op_data = seq_bytes[step_q];
            op_rd   = !write_q && (step_q >= STEP_W'(HALVES));
        end
    end

    // Request state, step counter and read-data assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            mode_q     <= 1'b0;
            write_q    <= 1'b0;
            launched_q <= 1'b0;
            done_q     <= 1'b0;
            step_q     <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            mbyte_q    <= '0;
            acc_q      <= '0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q     <= 1'b1;
                mode_q     <= mode_valid;
                write_q    <= cmd_write;
                addr_q     <= cmd_addr;
                wdata_q    <= cmd_wdata;
                mbyte_q    <= mode_byte;
                step_q     <= '0;
                launched_q <= 1'b0;
            end else if (busy_q) begin
                if (start) begin
                    launched_q <= 1'b1;
                end
                if (eng_fin) begin
                    launched_q <= 1'b0;
                    if (op_rd) begin
                        acc_q <= eng_rbyte;
                    end
                    if (last_step) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        if (op_rd) begin
                            rdata_q <= {acc_q, eng_rbyte};
                        end
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/ind_reg_master.sv
// Module: ind_reg_master (top)
// Host-side master for 16-bit register access through an 8-bit windowed
// asynchronous bus. It joins the access sequencer to the byte-cycle engine.
// Assumes an external pad ring turns bus_dout/bus_oe/bus_din into a tristate bus.
module ind_reg_master
    import irm_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int REG_W = 16,
    parameter int OFF_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_strobe,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [REG_W-1:0] cmd_addr,
    input  logic [REG_W-1:0] cmd_wdata,
    input  logic             mode_valid,
    input  logic [BUS_W-1:0] mode_byte,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rdata,
    output logic [OFF_W-1:0] bus_addr,
    output logic             bus_cs_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_dout,
    input  logic [BUS_W-1:0] bus_din
);
    logic             eng_start, eng_idle, eng_fin, eng_rd;
    logic [OFF_W-1:0] eng_off;
    logic [BUS_W-1:0] eng_data, eng_rbyte;

    irm_access_seq #(.BUS_W(BUS_W), .REG_W(REG_W), .OFF_W(OFF_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .mode_valid(mode_valid), .mode_byte(mode_byte),
        .eng_idle(eng_idle), .eng_fin(eng_fin), .eng_rbyte(eng_rbyte),
        .start(eng_start), .op_off(eng_off), .op_data(eng_data), .op_rd(eng_rd),
        .busy(busy), .done(done), .rdata(rdata)
    );

    irm_byte_cycle #(.BUS_W(BUS_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_gap(cfg_gap),
        .start(eng_start), .op_off(eng_off), .op_data(eng_data), .op_rd(eng_rd),
        .idle(eng_idle), .fin(eng_fin), .rbyte(eng_rbyte),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .bus_din(bus_din)
    );
endmodule

// File: rtl/ind_reg_master_chk.sv
// Module: ind_reg_master_chk
// Protocol checker bound to ind_reg_master. It watches the bus pins against
// busy/done and the configured strobe length.
// Assumes cfg_strobe holds steady while a byte cycle runs.
module ind_reg_master_chk #(
    parameter int BUS_W = 8,
    parameter int OFF_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_strobe,
    input logic             busy,
    input logic             done,
    input logic [OFF_W-1:0] bus_addr,
    input logic             bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             bus_oe,
    input logic [BUS_W-1:0] bus_dout
);
    localparam int LW = CNT_W + 1;
    logic [LW-1:0] low_cnt;

    // Count consecutive chip-select-low clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!bus_cs_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe));

    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_oe && bus_wr_n && !bus_cs_n));

    a_r5_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (bus_oe && bus_rd_n && !bus_cs_n));

    a_r6_setup_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_dout)));

    a_r6_hold_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_dout) && $stable(bus_oe)));

    a_r6_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> (low_cnt == LW'(cfg_strobe) + 1'b1));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind ind_reg_master ind_reg_master_chk #(.BUS_W(BUS_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .busy(busy), .done(done),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout)
);

// File: tb/ind_reg_master_tb_top.sv
`timescale 1ns/1ps
module ind_reg_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_setup = 4'd0, cfg_strobe = 4'd0, cfg_gap = 4'd0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        mode_valid = 1'b0;
    logic [7:0]  mode_byte = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic [2:0]  bus_addr;
    logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_oe;
    logic [7:0]  bus_dout, bus_din;

    ind_reg_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_gap(cfg_gap), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .mode_valid(mode_valid),
        .mode_byte(mode_byte), .busy(busy), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] init_val(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    // Peripheral model: window registers and a small register file
    logic [15:0] mem [0:255];
    logic [15:0] ia = '0;
    logic [7:0]  pend_hi = '0;
    logic [7:0]  mode_last = '0;
    logic [2:0]  log_off [0:1023];
    logic [7:0]  log_dat [0:1023];
    logic        log_wr  [0:1023];
    int          log_n = 0;
    logic        prev_cs = 1'b1;
    int          high_run = 0, low_run = 0;
    int          acc_base = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
    end

    // Read data is only valid while chip select and the read strobe are low
    always_comb begin
        bus_din = 8'hEE;
        if (!bus_cs_n && !bus_rd_n) begin
            if (bus_addr == 3'd4) bus_din = mem[ia[7:0]][15:8];
            else if (bus_addr == 3'd5) bus_din = mem[ia[7:0]][7:0];
        end
    end

    // Bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !bus_cs_n) begin
                if (log_n > acc_base)
                    chk(high_run == cfg_gap + cfg_setup + 3, "R6 gap", high_run, cfg_gap + cfg_setup + 3);
                chk((bus_rd_n != bus_wr_n) && (bus_oe == !bus_wr_n), "R5 strobe", {bus_rd_n, bus_wr_n, bus_oe}, {!bus_wr_n, bus_wr_n, !bus_wr_n});
                if (log_n < 1024) begin
                    log_off[log_n] = bus_addr;
                    log_dat[log_n] = bus_dout;
                    log_wr[log_n]  = !bus_wr_n;
                    log_n++;
                end
                if (!bus_wr_n) begin
                    case (bus_addr)
                        3'd1: mode_last = bus_dout;
                        3'd2: ia[15:8] = bus_dout;
                        3'd3: ia[7:0] = bus_dout;
                        3'd4: pend_hi = bus_dout;
                        3'd5: mem[ia[7:0]] = {pend_hi, bus_dout};
                        default: ;
                    endcase
                end
                low_run = 1;
                high_run = 0;
            end else if (!prev_cs && bus_cs_n) begin
                chk(low_run == cfg_strobe + 1, "R6 strobe", low_run, cfg_strobe + 1);
                high_run = 1;
            end else if (bus_cs_n) begin
                high_run++;
            end else begin
                low_run++;
            end
            prev_cs = bus_cs_n;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // One request; returns the cycle of done (cycle 0 = accept) and rdata
    task automatic run_req(input bit cv, input bit cw, input logic [15:0] ca,
                           input logic [15:0] cd, input bit mv, input logic [7:0] mb,
                           input bit inject, output int done_n, output logic [15:0] got);
        int busy_bad;
        busy_bad = 0;
        done_n = -1;
        got = '0;
        @(negedge clk); #1;
        acc_base = log_n;
        cmd_valid = cv; cmd_write = cw; cmd_addr = ca; cmd_wdata = cd;
        mode_valid = mv; mode_byte = mb;
        for (int n = 1; n < 3000; n++) begin
            @(negedge clk); #1;
            if (n == 1) begin cmd_valid = 1'b0; mode_valid = 1'b0; end
            if (inject && n == 3) begin
                cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'hDEAD; cmd_wdata = 16'h0BAD;
                mode_valid = 1'b1; mode_byte = 8'h80;
            end
            if (inject && n == 4) begin cmd_valid = 1'b0; mode_valid = 1'b0; end
            if (done) begin
                done_n = n;
                got = rdata;
                chk(!busy, "R7 busy low at done", busy, 0);
                break;
            end
            if (!busy) busy_bad++;
        end
        chk(busy_bad == 0, "R7 busy held", busy_bad, 0);
        @(negedge clk); #1;
        chk(!done && bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe, "R1 idle after done",
            {done, bus_cs_n, bus_rd_n, bus_wr_n, bus_oe}, 5'b01110);
    endtask

    task automatic chk_entry(input int k, input logic [2:0] off, input logic [7:0] dat,
                             input bit wr, input string req);
        int i;
        i = acc_base + k;
        chk(log_off[i] == off && log_wr[i] == wr, req, {log_wr[i], log_off[i]}, {wr, off});
        if (wr) chk(log_dat[i] == dat, req, log_dat[i], dat);
    endtask

    initial begin
        int dn, len, idx;
        logic [15:0] got, a, d, b;
        logic [7:0] mb;
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe && !busy && !done, "R1 in reset",
            {bus_cs_n, bus_rd_n, bus_wr_n, bus_oe, busy, done}, 6'b111000);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe && !busy && !done, "R1 after reset",
            {bus_cs_n, bus_rd_n, bus_wr_n, bus_oe, busy, done}, 6'b111000);
        idx = 0;
        for (int s = 0; s < 3; s++) begin
            for (int t = 0; t < 3; t++) begin
                for (int g = 0; g < 2; g++) begin
                    @(negedge clk); #1;
                    cfg_setup = 4'(s); cfg_strobe = 4'(t); cfg_gap = 4'(g);
                    len = s + t + g + 4;
                    a = {8'h40 + 8'(idx), 8'(2 * idx)};
                    b = {8'h80, 8'(2 * idx + 1)};
                    d = 16'h1234 ^ (16'(idx) * 16'h0B1D);
                    mb = idx[0] ? 8'h81 : 8'h01;

                    // Write, possibly with requests injected while busy
                    run_req(1'b1, 1'b1, a, d, 1'b0, 8'h00, (idx % 3) == 0, dn, got);
                    chk(dn == 4 * len + 1, "R7 write done cycle", dn, 4 * len + 1);
                    chk(log_n - acc_base == 4, "R8 R2 write byte count", log_n - acc_base, 4);
                    chk_entry(0, 3'd2, a[15:8], 1'b1, "R2 addr hi");
                    chk_entry(1, 3'd3, a[7:0], 1'b1, "R2 addr lo");
                    chk_entry(2, 3'd4, d[15:8], 1'b1, "R2 data hi");
                    chk_entry(3, 3'd5, d[7:0], 1'b1, "R2 data lo");

                    // Read back the written register
                    run_req(1'b1, 1'b0, a, 16'hFFFF, 1'b0, 8'h00, 1'b0, dn, got);
                    chk(dn == 4 * len + 1, "R7 read done cycle", dn, 4 * len + 1);
                    chk(log_n - acc_base == 4, "R3 read byte count", log_n - acc_base, 4);
                    chk_entry(0, 3'd2, a[15:8], 1'b1, "R3 addr hi");
                    chk_entry(1, 3'd3, a[7:0], 1'b1, "R3 addr lo");
                    chk_entry(2, 3'd4, 8'h00, 1'b0, "R3 data hi read");
                    chk_entry(3, 3'd5, 8'h00, 1'b0, "R3 data lo read");
                    chk(got == d, "R3 rdata written", got, d);

                    // Read an untouched register
                    run_req(1'b1, 1'b0, b, 16'h0000, 1'b0, 8'h00, 1'b0, dn, got);
                    chk(got == init_val(b[7:0]), "R3 rdata initial", got, init_val(b[7:0]));

                    // Mode byte, with a clashing command on odd configurations
                    run_req(idx[0], 1'b1, 16'hBEEF, 16'h5555, 1'b1, mb, 1'b0, dn, got);
                    chk(dn == len + 1, "R9 R4 mode done cycle", dn, len + 1);
                    chk(log_n - acc_base == 1, "R9 single byte", log_n - acc_base, 1);
                    chk_entry(0, 3'd1, mb, 1'b1, "R4 mode write");
                    chk(mode_last == mb, "R4 mode reg", mode_last, mb);
                    idx++;
                end
            end
        end
        // Injected write to 0xDEAD must never have happened
        run_req(1'b1, 1'b0, 16'hDEAD, 16'h0000, 1'b0, 8'h00, 1'b0, dn, got);
        chk(got == init_val(8'hAD), "R8 ignored write", got, init_val(8'hAD));
        run_req(1'b1, 1'b0, 16'hBEEF, 16'h0000, 1'b0, 8'h00, 1'b0, dn, got);
        chk(got == init_val(8'hEF), "R9 dropped command", got, init_val(8'hEF));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule